// File: doc/BRIEF.md
# Serial Flash Write Protection Controller

This block holds every piece of state that decides whether a serial flash device may change its contents. It keeps the write-enable latch, four block-protect bits, a status-write-disable bit, a busy (write-in-progress) flag, a deep-sleep flag, and the state of a small one-time-programmable secure area. It also keeps that area's sticky lock bit. The SPI front end hands it one decoded command per `cmd_valid` pulse. Each command comes with its address, status-write data, and a flag that says whether chip select rose on a byte boundary.

One cycle after each command the block answers with exactly one of `cmd_grant` or `cmd_deny`, and it updates its state at that same edge. A granted program or erase sets the busy flag. An external sequencer clears it with a pulse on `op_done`. The status byte is always visible on `status_reg`. The mapping from block-protect code to a protected address range is a parameterised comparator over fixed-size blocks.

Top module: `wpc_top`

## Requirements
- R1: The write-enable latch (`status_reg` bit 1) becomes set only when a write-enable command (code 1) is granted.
- R2: The following commands are denied while the write-enable latch is clear: status write (code 4), program (code 6), sector erase (code 7), block erase (code 8) and chip erase (code 9).
- R3: The write-enable latch is cleared when any of these commands is granted: write-disable (code 2), status write, program, sector erase, block erase or chip erase.
- R4: A block-protect code n (`status_reg` bits 5:2) of 1 or more protects the top 2^(n-1) blocks of 64 KiB, or the whole array when 2^(n-1) reaches the block count. Program, sector erase and block erase aimed inside the protected range are denied. Chip erase is denied whenever n is nonzero.
- R5: While `wp_n` is low and the status-write-disable bit (`status_reg` bit 7) is set, a status write is denied and the status byte is left unchanged. Otherwise a granted status write loads bits 7 and 5:2 from `cmd_wdata`.
- R6: A granted sleep command (code 10) sets `deep_sleep`. While `deep_sleep` is set, only wake (code 11) and signature read (code 12) are granted, and a granted wake clears `deep_sleep`.
- R7: After reset, `status_reg` is 0x00, and `deep_sleep`, `otp_mode`, `otp_locked`, `cmd_grant` and `cmd_deny` are all low.
- R8: Between enter-secure-area (code 13) and exit-secure-area (code 14), a granted program raises `grant_to_otp` and skips the array protection check. In that window erases are denied. Once lock-secure-area (code 15) has been granted, `otp_locked` stays high and secure-area programs are denied.
- R9: A granted program or erase sets `status_reg` bit 0. While that bit is set, status write, program, erases, sleep and lock are denied. A pulse on `op_done` clears the bit.
- R10: Every command other than codes 0, 3, 5 and 12 is denied with no effect when `cmd_aligned` is low. Those four read codes are granted regardless of `cmd_aligned`.
- R11: For each `cmd_valid` cycle, exactly one of `cmd_grant` or `cmd_deny` is high on the following cycle. Both are low otherwise. Bit 6 of `status_reg` reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One decoded command is present this cycle |
| cmd_op | input | 4 | Command code |
| cmd_addr | input | 24 | Target byte address |
| cmd_wdata | input | 8 | Data byte for status write |
| cmd_aligned | input | 1 | Chip select rose on a byte boundary |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Program or erase has finished |
| cmd_grant | output | 1 | Previous command accepted |
| cmd_deny | output | 1 | Previous command refused |
| grant_to_otp | output | 1 | Accepted program targets the secure area |
| status_reg | output | 8 | Status byte |
| deep_sleep | output | 1 | Deep power-down active |
| otp_mode | output | 1 | Secure area selected |
| otp_locked | output | 1 | Secure area lock bit |

## Verification
The bench probes the edges of the protected range: the first protected block and the last free block for two codes, plus a code large enough to cover the whole array. A design with an off-by-one in the comparator would let a write into the first protected block or refuse one into the last free block. The bench also retries modify commands in awkward states: during busy, in deep sleep, after a misaligned end, and with the pin frozen. A design that checks these conditions in the wrong order would still move the write-enable latch or the protect bits on a refused command. In the secure-area sequence, a design that kept applying array protection, or that forgot the lock, would grant or refuse the wrong program.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [3:0] {
    OP_IDENT   = 4'd0,
    OP_WEN     = 4'd1,
    OP_WDIS    = 4'd2,
    OP_STRD    = 4'd3,
    OP_STWR    = 4'd4,
    OP_ARD     = 4'd5,
    OP_PROG    = 4'd6,
    OP_ERS_SEC = 4'd7,
    OP_ERS_BLK = 4'd8,
    OP_ERS_ALL = 4'd9,
    OP_SLEEP   = 4'd10,
    OP_WAKE    = 4'd11,
    OP_SIG     = 4'd12,
    OP_SEC_IN  = 4'd13,
    OP_SEC_OUT = 4'd14,
    OP_SEC_LCK = 4'd15
  } wpc_op_e;

  typedef struct packed {
    logic       wel;
    logic       wip;
    logic [3:0] bp;
    logic       srwd;
    logic       dpd;
    logic       sec_mode;
    logic       sec_lock;
  } wpc_state_t;

  typedef struct packed {
    logic grant;
    logic set_wel;
    logic clr_wel;
    logic set_wip;
    logic wr_stat;
    logic set_dpd;
    logic clr_dpd;
    logic set_sec;
    logic clr_sec;
    logic set_lock;
    logic to_otp;
  } wpc_effect_t;
endpackage

// File: rtl/wpc_zone_check.sv
module wpc_zone_check #(
  parameter int ADDR_W   = 24,
  parameter int BLOCK_W  = 16,
  parameter bit FROM_TOP = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        code,
  output logic              hit
);
  localparam int IDX_W = ADDR_W - BLOCK_W;
  localparam int CW    = IDX_W + 1;
  localparam int NBLK  = 1 << IDX_W;

  logic [CW-1:0] idx;
  logic [CW-1:0] count;
  int            sh;

  assign idx = {1'b0, addr[ADDR_W-1:BLOCK_W]};

  always_comb begin
    sh = int'(code) - 1;
    if (code == 4'd0) begin
      count = '0;
    end else if (sh >= IDX_W) begin
      count = CW'(NBLK);
    end else begin
      count = CW'(32'd1 << sh);
    end
  end

  generate
    if (FROM_TOP) begin : g_top
      assign hit = (count != '0) && (idx >= (CW'(NBLK) - count));
    end else begin : g_bottom
      assign hit = (count != '0) && (idx < count);
    end
  endgenerate
endmodule

// File: rtl/wpc_gatekeeper.sv
module wpc_gatekeeper
  import wpc_pkg::*;
(
  input  logic [3:0]  op,
  input  logic        aligned,
  input  logic        wp_n,
  input  logic        zone_hit,
  input  wpc_state_t  st,
  output wpc_effect_t eff
);
  logic is_read, needs_wel, is_modify, is_erase, frozen, refuse;

  always_comb begin
    is_read   = (op == OP_IDENT) || (op == OP_STRD) || (op == OP_ARD) || (op == OP_SIG);
    is_erase  = (op == OP_ERS_SEC) || (op == OP_ERS_BLK) || (op == OP_ERS_ALL);
    needs_wel = (op == OP_STWR) || (op == OP_PROG) || is_erase;
    is_modify = needs_wel || (op == OP_SLEEP) || (op == OP_SEC_LCK);
    frozen    = !wp_n && st.srwd;

    refuse = 1'b0;
    if (st.dpd && (op != OP_WAKE) && (op != OP_SIG)) refuse = 1'b1;
    if (!is_read && !aligned)                        refuse = 1'b1;
    if (st.wip && is_modify)                         refuse = 1'b1;
    if (needs_wel && !st.wel)                        refuse = 1'b1;
    if ((op == OP_STWR) && frozen)                   refuse = 1'b1;
    if ((op == OP_PROG) && st.sec_mode && st.sec_lock) refuse = 1'b1;
    if ((op == OP_PROG) && !st.sec_mode && zone_hit) refuse = 1'b1;
    if (is_erase && st.sec_mode)                     refuse = 1'b1;
    if (((op == OP_ERS_SEC) || (op == OP_ERS_BLK)) && zone_hit) refuse = 1'b1;
    if ((op == OP_ERS_ALL) && (st.bp != 4'd0))       refuse = 1'b1;

    eff          = '0;
    eff.grant    = !refuse;
    if (!refuse) begin
      eff.set_wel  = (op == OP_WEN);
      eff.clr_wel  = (op == OP_WDIS) || needs_wel;
      eff.set_wip  = (op == OP_PROG) || is_erase;
      eff.wr_stat  = (op == OP_STWR);
      eff.set_dpd  = (op == OP_SLEEP);
      eff.clr_dpd  = (op == OP_WAKE);
      eff.set_sec  = (op == OP_SEC_IN);
      eff.clr_sec  = (op == OP_SEC_OUT);
      eff.set_lock = (op == OP_SEC_LCK);
      eff.to_otp   = (op == OP_PROG) && st.sec_mode;
    end
  end
endmodule

// File: rtl/wpc_top.sv
module wpc_top
  import wpc_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int BLOCK_W  = 16,
  parameter bit FROM_TOP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  input  logic              cmd_aligned,
  input  logic              wp_n,
  input  logic              op_done,
  output logic              cmd_grant,
  output logic              cmd_deny,
  output logic              grant_to_otp,
  output logic [7:0]        status_reg,
  output logic              deep_sleep,
  output logic              otp_mode,
  output logic              otp_locked
);
  wpc_state_t  st_q, st_d;
  wpc_effect_t eff;
  logic        zone_hit;
  logic        grant_q, deny_q, otp_q;
  logic        grant_d, deny_d, otp_d;

  wpc_zone_check #(
    .ADDR_W  (ADDR_W),
    .BLOCK_W (BLOCK_W),
    .FROM_TOP(FROM_TOP)
  ) u_zone (
    .addr(cmd_addr),
    .code(st_q.bp),
    .hit (zone_hit)
  );

  wpc_gatekeeper u_gate (
    .op      (cmd_op),
    .aligned (cmd_aligned),
    .wp_n    (wp_n),
    .zone_hit(zone_hit),
    .st      (st_q),
    .eff     (eff)
  );

  always_comb begin
    st_d    = st_q;
    grant_d = 1'b0;
    deny_d  = 1'b0;
    otp_d   = 1'b0;
    if (op_done) st_d.wip = 1'b0;
    if (cmd_valid) begin
      grant_d = eff.grant;
      deny_d  = !eff.grant;
      otp_d   = eff.to_otp;
      if (eff.set_wel)  st_d.wel      = 1'b1;
      if (eff.clr_wel)  st_d.wel      = 1'b0;
      if (eff.set_wip)  st_d.wip      = 1'b1;
      if (eff.set_dpd)  st_d.dpd      = 1'b1;
      if (eff.clr_dpd)  st_d.dpd      = 1'b0;
      if (eff.set_sec)  st_d.sec_mode = 1'b1;
      if (eff.clr_sec)  st_d.sec_mode = 1'b0;
      if (eff.set_lock) st_d.sec_lock = 1'b1;
      if (eff.wr_stat) begin
        st_d.srwd = cmd_wdata[7];
        st_d.bp   = cmd_wdata[5:2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
      otp_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      grant_q <= grant_d;
      deny_q  <= deny_d;
      otp_q   <= otp_d;
    end
  end

  assign cmd_grant    = grant_q;
  assign cmd_deny     = deny_q;
  assign grant_to_otp = otp_q;
  assign status_reg   = {st_q.srwd, 1'b0, st_q.bp, st_q.wel, st_q.wip};
  assign deep_sleep   = st_q.dpd;
  assign otp_mode     = st_q.sec_mode;
  assign otp_locked   = st_q.sec_lock;
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [3:0]        cmd_op,
  input logic              cmd_aligned,
  input logic              wp_n,
  input logic              op_done,
  input logic              cmd_grant,
  input logic              cmd_deny,
  input logic [7:0]        status_reg,
  input logic              deep_sleep,
  input logic              otp_locked
);
  AST_WEL_ONLY_BY_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_reg[1]) |-> $past(cmd_valid && (cmd_op == 4'd1))); // R1
  AST_PROG_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 4'd6) && !status_reg[1]) |=> cmd_deny); // R2
  AST_FROZEN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 4'd4) && !wp_n && status_reg[7])
      |=> (cmd_deny && (status_reg[7:2] == $past(status_reg[7:2])))); // R5
  AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && deep_sleep && (cmd_op != 4'd11) && (cmd_op != 4'd12)) |=> cmd_deny); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(otp_locked) |-> otp_locked); // R8
  AST_BUSY_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && status_reg[0] && (cmd_op == 4'd6)) |=> cmd_deny); // R9
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && status_reg[0]) |=> !status_reg[0]); // R9
  AST_MISALIGN_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_aligned && (cmd_op == 4'd1)) |=> (cmd_deny && $stable(status_reg))); // R10
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (cmd_grant ^ cmd_deny)); // R11
  AST_NO_STRAY_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !(cmd_grant || cmd_deny)); // R11
endmodule

bind wpc_top wpc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_aligned(cmd_aligned),
  .wp_n       (wp_n),
  .op_done    (op_done),
  .cmd_grant  (cmd_grant),
  .cmd_deny   (cmd_deny),
  .status_reg (status_reg),
  .deep_sleep (deep_sleep),
  .otp_locked (otp_locked)
);

// File: tb/tb_wpc_top.sv
module tb_wpc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = 4'd0;
  logic [23:0] cmd_addr = 24'd0;
  logic [7:0]  cmd_wdata = 8'd0;
  logic        cmd_aligned = 1'b1;
  logic        wp_n = 1'b1;
  logic        op_done = 1'b0;
  logic        cmd_grant, cmd_deny, grant_to_otp, deep_sleep, otp_mode, otp_locked;
  logic [7:0]  status_reg;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  wpc_top dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_aligned(cmd_aligned),
    .wp_n(wp_n), .op_done(op_done), .cmd_grant(cmd_grant), .cmd_deny(cmd_deny),
    .grant_to_otp(grant_to_otp), .status_reg(status_reg), .deep_sleep(deep_sleep),
    .otp_mode(otp_mode), .otp_locked(otp_locked)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Issue one command; returns 1 if granted. Sampling at the negedge after the capturing posedge.
  task automatic issue(input logic [3:0] op, input logic [23:0] a, input logic [7:0] d,
                       input logic al, output bit g);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_aligned = al;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_aligned = 1'b1;
    g = cmd_grant;
    if (cmd_grant == cmd_deny) begin
      n_checks++; n_fail++;
      $display("FAIL R11 grant=%0b deny=%0b expected exactly one", cmd_grant, cmd_deny);
    end
  endtask

  task automatic pulse_done();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R7 status", status_reg, 8'h00);
    check("R7 sleep", deep_sleep, 0);
    check("R7 otp", {otp_mode, otp_locked}, 0);
    check("R11 idle answer", {cmd_grant, cmd_deny}, 0);
  endtask

  task automatic t_wel();
    bit g;
    issue(4'd6, 24'h000100, 8'h00, 1'b1, g); check("R2 prog without latch", g, 0);
    issue(4'd1, 24'h0, 8'h00, 1'b0, g);      check("R10 misaligned enable", g, 0);
    check("R10 latch untouched", status_reg, 8'h00);
    issue(4'd5, 24'h0, 8'h00, 1'b0, g);      check("R10 misaligned read granted", g, 1);
    issue(4'd1, 24'h0, 8'h00, 1'b1, g);      check("R1 enable granted", g, 1);
    check("R1 latch set", status_reg, 8'h02);
    issue(4'd2, 24'h0, 8'h00, 1'b1, g);      check("R3 disable clears", status_reg, 8'h00);
    @(negedge clk); check("R11 no stray answer", {cmd_grant, cmd_deny}, 0);
  endtask

  task automatic t_protect();
    bit g;
    issue(4'd1, 0, 0, 1, g);
    issue(4'd4, 0, 8'h8C, 1, g);             check("R5 status write", status_reg, 8'h8C);
    issue(4'd1, 0, 0, 1, g);
    issue(4'd6, 24'hFC0000, 0, 1, g);        check("R4 first protected block", g, 0);
    check("R4 latch kept on deny", status_reg, 8'h8E);
    issue(4'd9, 0, 0, 1, g);                 check("R4 chip erase refused", g, 0);
    issue(4'd6, 24'hFBFFFF, 0, 1, g);        check("R4 last free block", g, 1);
    check("R9 busy set and R3 latch cleared", status_reg, 8'h8D);
    issue(4'd1, 0, 0, 1, g);
    issue(4'd6, 24'h000000, 0, 1, g);        check("R9 prog while busy", g, 0);
    issue(4'd4, 0, 8'h00, 1, g);             check("R9 status write while busy", g, 0);
    pulse_done();                            check("R9 done clears busy", status_reg, 8'h8E);
  endtask

  task automatic t_freeze();
    bit g;
    wp_n = 1'b0;
    issue(4'd4, 0, 8'h00, 1, g);             check("R5 frozen write refused", g, 0);
    check("R5 frozen bits unchanged", status_reg, 8'h8E);
    wp_n = 1'b1;
    issue(4'd4, 0, 8'h24, 1, g);             check("R5 unfrozen write", status_reg, 8'h24);
    issue(4'd1, 0, 0, 1, g);
    issue(4'd7, 24'h000000, 0, 1, g);        check("R4 whole array code 9", g, 0);
    issue(4'd4, 0, 8'h04, 1, g);             check("R3 status write clears latch", status_reg, 8'h04);
    issue(4'd1, 0, 0, 1, g);
    issue(4'd8, 24'hFF0000, 0, 1, g);        check("R4 code 1 top block", g, 0);
    issue(4'd8, 24'hFEFFFF, 0, 1, g);        check("R4 code 1 next block", g, 1);
    pulse_done();                            check("R9 erase done", status_reg, 8'h04);
  endtask

  task automatic t_sleep();
    bit g;
    issue(4'd10, 0, 0, 0, g);                check("R10 misaligned sleep", g, 0);
    issue(4'd10, 0, 0, 1, g);                check("R6 sleep granted", deep_sleep, 1);
    issue(4'd1, 0, 0, 1, g);                 check("R6 enable refused asleep", g, 0);
    check("R6 latch untouched asleep", status_reg, 8'h04);
    issue(4'd5, 0, 0, 1, g);                 check("R6 read refused asleep", g, 0);
    issue(4'd12, 0, 0, 1, g);                check("R6 signature granted asleep", g, 1);
    check("R6 still asleep", deep_sleep, 1);
    issue(4'd11, 0, 0, 1, g);                check("R6 wake", {g, deep_sleep}, 2);
  endtask

  task automatic t_secure();
    bit g;
    issue(4'd13, 0, 0, 1, g);                check("R8 enter area", otp_mode, 1);
    issue(4'd1, 0, 0, 1, g);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 4'd6; cmd_addr = 24'hFF0000; cmd_aligned = 1;
    @(negedge clk);
    cmd_valid = 0;
    check("R8 area program routed", {cmd_grant, grant_to_otp}, 3);
    pulse_done();
    issue(4'd1, 0, 0, 1, g);
    issue(4'd7, 24'h0, 0, 1, g);             check("R8 erase in area refused", g, 0);
    issue(4'd15, 0, 0, 1, g);                check("R8 lock", otp_locked, 1);
    issue(4'd6, 24'h0, 0, 1, g);             check("R8 locked program refused", g, 0);
    issue(4'd14, 0, 0, 1, g);                check("R8 leave area", {otp_mode, otp_locked}, 1);
    issue(4'd6, 24'h000000, 0, 1, g);        check("R8 array program after exit", {g, grant_to_otp}, 2);
    pulse_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wel();
    t_protect();
    t_freeze();
    t_sleep();
    t_secure();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule